// File: doc/BRIEF.md
# Low-Speed USB Bit Receiver

This block turns the two wires of a low-speed USB link into a stream of received bytes. Each pin passes through a two-flop synchronizer and is then watched by a clock running at eight times the 1.5 Mb/s bit rate. The receiver first waits for the idle J level. It then follows the K edges of the sync field until one bit-centre sample after such an edge shows a second K. That pair of K bits closes the sync field and starts reception.

During reception, a phase counter realigns on every line transition and samples each bit near its middle. Each sample is NRZI-decoded, stuffed bits are removed, and the data bits are packed into bytes with the least significant bit first. Each complete byte is presented on a one-cycle strobe. A single-ended zero ends the packet with an end-of-packet pulse. A byte count beyond the configured buffer size aborts the packet with an overflow pulse. PID, CRC and endpoint handling belong to the layer above.

Top module: `lsusb_rx`

## Requirements
- R1: While reset is asserted, rx_byte is 0 and rx_valid, rx_eop, rx_overflow and rx_active are all low.
- R2: The line states are decoded from the pair {usb_dp, usb_dm}: J = 01, K = 10, SE0 = 00. After a J, a J-to-K edge followed by K at the next bit centre locks reception, and rx_active rises. The sync field is K,J,K,J,K,J,K,K in time order.
- R3: If the bit after a K edge is not K, reception does not start, and the receiver waits for the next K edge. A sync field cut short after its third J causes no activity on any output.
- R4: If no K arrives within KWAIT clock cycles after the J wait ends, the receiver abandons the event and must see J again. A K that follows a long SE0 without an intervening J does not lock.
- R5: NRZI decoding treats the level before the first data bit as K. An unchanged level decodes as 1 and a changed level decodes as 0.
- R6: After six decoded 1s in a row, the next bit is dropped without advancing the bit position. The final sync bit counts as the first of those 1s, and the dropped bit may fall at any of the eight positions.
- R7: Data bits fill each byte least significant bit first. Every completed byte appears on rx_byte together with a one-cycle rx_valid pulse.
- R8: SE0 at a bit-centre sample during reception produces a one-cycle rx_eop pulse. rx_active is already low in that same cycle.
- R9: Byte number MAX_BYTES+1 raises a one-cycle rx_overflow in place of rx_valid. No rx_eop follows for that packet, and the line is ignored until SE0.
- R10: Each observed transition realigns the bit phase, and a sample is taken OVS/2+1 cycles after a transition is detected. A transition detected in the same cycle as a sample both yields the level before it and realigns. Bits between OVS/2+1 and 2*OVS-(OVS/2+1) cycles long decode correctly.
- R11: rx_active stays high from lock until the end of the packet (EOP or overflow), and rx_valid only pulses while rx_active is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | D+ line, asynchronous |
| usb_dm | input | 1 | D- line, asynchronous |
| rx_byte | output | 8 | Last received byte, LSB received first |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| rx_eop | output | 1 | One-cycle end-of-packet pulse |
| rx_overflow | output | 1 | One-cycle pulse when the byte limit is exceeded |
| rx_active | output | 1 | High while a packet is being received |

## Verification
A line transition and a bit-centre sample can fall in the same clock cycle. When they do, the sample must take the old level and the phase counter must still restart from the new edge. The bench provokes this in a jittered packet by shortening selected bits to OVS/2+1 cycles; it picks only bits that begin and end with a transition and lengthens the bit that follows. The decoded bytes are then compared against a behavioural reference that encodes the packet with NRZI and stuffing. A dropped or shifted bit shows up as a byte mismatch, or as an end of packet with bytes still expected.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

   // Line level as {dp, dm}
   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10,
      LN_SE1 = 2'b11
   } line_t;

   typedef enum logic [2:0] {
      ST_WAIT_J,
      ST_WAIT_K,
      ST_CHECK_K,
      ST_RECV,
      ST_DRAIN
   } rx_state_t;

endpackage

// File: rtl/lsrx_sync.sv
module lsrx_sync #(
   parameter int            W      = 2,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  INIT   = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lsrx_sync needs at least two stages");
   end

   logic [W-1:0] chain_r [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_r[i] <= INIT;
      end else begin
         chain_r[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_r[i] <= chain_r[i-1];
      end
   end

   assign q = chain_r[STAGES-1];

endmodule

// File: rtl/lsrx_phase.sv
module lsrx_phase #(
   parameter int OVS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic realign,
   output logic sample
);

   localparam int              PW   = $clog2(OVS);
   localparam logic [PW-1:0]   HALF = PW'(OVS / 2);
   localparam logic [PW-1:0]   LAST = PW'(OVS - 1);

   logic [PW-1:0] ph_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ph_r <= '0;
      else if (realign)        ph_r <= '0;
      else if (ph_r == LAST)   ph_r <= '0;
      else                     ph_r <= ph_r + 1'b1;
   end

   assign sample = (ph_r == HALF);

   AST_SAMPLE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> !sample);  // R10

endmodule

// File: rtl/lsrx_unpack.sv
module lsrx_unpack #(
   parameter int BYTE_W    = 8,
   parameter int STUFF_RUN = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              take,
   input  logic              level,
   output logic              done,
   output logic [BYTE_W-1:0] data
);

   localparam int             IW   = $clog2(BYTE_W);
   localparam int             OW   = $clog2(STUFF_RUN + 1);
   localparam logic [IW-1:0]  IEND = IW'(BYTE_W - 1);
   localparam logic [OW-1:0]  OMAX = OW'(STUFF_RUN);

   logic              prev_lvl_r;
   logic [OW-1:0]     ones_r;
   logic [IW-1:0]     idx_r;
   logic [BYTE_W-1:0] shreg_r;
   logic              bit_d;
   logic              stuffed;

   assign bit_d   = (level == prev_lvl_r);
   assign stuffed = (ones_r == OMAX);
   assign data    = {bit_d, shreg_r[BYTE_W-1:1]};
   assign done    = take && !stuffed && (idx_r == IEND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl_r <= 1'b1;
         ones_r     <= '0;
         idx_r      <= '0;
         shreg_r    <= '0;
      end else if (clear) begin
         prev_lvl_r <= 1'b1;               // closing sync bit is K
         ones_r     <= OW'(1);             // and decodes as a 1
         idx_r      <= '0;
         shreg_r    <= '0;
      end else if (take) begin
         prev_lvl_r <= level;
         if (stuffed) begin
            ones_r <= '0;
         end else begin
            shreg_r <= data;
            idx_r   <= (idx_r == IEND) ? '0 : idx_r + 1'b1;
            ones_r  <= bit_d ? ones_r + 1'b1 : '0;
         end
      end
   end

   AST_STUFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && stuffed) |=> ($stable(idx_r) && $stable(shreg_r)));  // R6

endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
   import lsrx_pkg::*;
#(
   parameter int OVS         = 8,
   parameter int MAX_BYTES   = 11,
   parameter int KWAIT       = 48,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       usb_dp,
   input  logic       usb_dm,
   output logic [7:0] rx_byte,
   output logic       rx_valid,
   output logic       rx_eop,
   output logic       rx_overflow,
   output logic       rx_active
);

   localparam int             NW   = $clog2(MAX_BYTES + 1);
   localparam int             TW   = $clog2(KWAIT + 1);
   localparam logic [NW-1:0]  NLIM = NW'(MAX_BYTES);
   localparam logic [TW-1:0]  TLIM = TW'(KWAIT - 1);

   if (OVS < 4 || KWAIT <= 2 * OVS || MAX_BYTES < 1) begin : g_bad_params
      $error("lsusb_rx: OVS >= 4, KWAIT > 2*OVS and MAX_BYTES >= 1 required");
   end

   logic [1:0] pins_s;
   line_t      line_q, line_p;
   logic       edge_seen, realign, smp;
   logic       lock, take, byte_done;
   logic [7:0] byte_data;
   rx_state_t  state;
   logic [TW-1:0] tmr;
   logic [NW-1:0] nbytes;
   logic          half_seen;

   lsrx_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b01)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({usb_dp, usb_dm}), .q(pins_s));

   assign line_q = line_t'(pins_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_p <= LN_J;
      else        line_p <= line_q;
   end

   assign edge_seen = (line_q != line_p);
   assign realign   = edge_seen || (state == ST_WAIT_K);

   lsrx_phase #(.OVS(OVS)) u_phase (
      .clk(clk), .rst_n(rst_n), .realign(realign), .sample(smp));

   assign lock = (state == ST_CHECK_K) && smp && (line_p == LN_K) && half_seen;
   assign take = (state == ST_RECV) && smp && (line_p != LN_SE0);

   lsrx_unpack #(.BYTE_W(8), .STUFF_RUN(6)) u_unpack (
      .clk(clk), .rst_n(rst_n), .clear(lock), .take(take),
      .level(line_p[1]), .done(byte_done), .data(byte_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_WAIT_J;
         tmr         <= '0;
         nbytes      <= '0;
         half_seen   <= 1'b0;
         rx_byte     <= '0;
         rx_valid    <= 1'b0;
         rx_eop      <= 1'b0;
         rx_overflow <= 1'b0;
      end else begin
         rx_valid    <= 1'b0;
         rx_eop      <= 1'b0;
         rx_overflow <= 1'b0;
         case (state)
            ST_WAIT_J: begin
               if (line_q == LN_J) begin
                  state <= ST_WAIT_K;
                  tmr   <= '0;
               end
            end
            ST_WAIT_K: begin
               if (line_q == LN_K) begin
                  state     <= ST_CHECK_K;
                  half_seen <= 1'b0;
               end else if (tmr == TLIM) begin
                  state <= ST_WAIT_J;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_CHECK_K: begin
               if (smp) begin
                  if (line_p != LN_K) begin
                     state <= ST_WAIT_K;
                     tmr   <= '0;
                  end else if (half_seen) begin
                     state  <= ST_RECV;
                     nbytes <= '0;
                  end else begin
                     half_seen <= 1'b1;
                  end
               end
            end
            ST_RECV: begin
               if (smp && line_p == LN_SE0) begin
                  rx_eop <= 1'b1;
                  state  <= ST_WAIT_J;
               end else if (byte_done) begin
                  if (nbytes == NLIM) begin
                     rx_overflow <= 1'b1;
                     state       <= ST_DRAIN;
                  end else begin
                     rx_valid <= 1'b1;
                     rx_byte  <= byte_data;
                     nbytes   <= nbytes + 1'b1;
                  end
               end
            end
            ST_DRAIN: begin
               if (line_q == LN_SE0) state <= ST_WAIT_J;
            end
            default: state <= ST_WAIT_J;
         endcase
      end
   end

   assign rx_active = (state == ST_RECV);

   AST_VALID_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_active);  // R11

   AST_EOP_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eop |-> (!rx_active && $past(rx_active)));  // R8

   AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_eop && rx_overflow) && !(rx_valid && (rx_eop || rx_overflow)));  // R9

   AST_LOCK_ON_K: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_active) |-> ($past(line_p) == LN_K));  // R2

   AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overflow |-> ($past(nbytes) == NLIM));  // R9

endmodule

// File: tb/tb_lsusb_rx.sv
`timescale 1ns/1ps
module tb_lsusb_rx;

   localparam int OVS   = 8;
   localparam int MAXB  = 11;
   localparam int KWAIT = 48;
   localparam int HALF  = OVS / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic usb_dp = 1'b0;
   logic usb_dm = 1'b1;
   logic [7:0] rx_byte;
   logic rx_valid, rx_eop, rx_overflow, rx_active;

   always #2.5 clk = ~clk;

   lsusb_rx #(.OVS(OVS), .MAX_BYTES(MAXB), .KWAIT(KWAIT)) dut (
      .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_eop(rx_eop),
      .rx_overflow(rx_overflow), .rx_active(rx_active));

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   byte unsigned exp_q[$];
   byte unsigned pk_q[$];
   int lv_q[$];
   int exp_end = 0;
   int got_end = 0;
   int exp_val = 0;
   bit quiet = 1'b0;
   bit quiet_hit = 1'b0;
   bit saw_active = 1'b0;
   string tag = "R7";

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // reference comparison every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (quiet) begin
            if (rx_active || rx_valid || rx_eop || rx_overflow) quiet_hit = 1'b1;
         end else begin
            if (rx_active) saw_active = 1'b1;
            if (rx_valid) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, tag, "unexpected byte", int'(rx_byte), 0);
               end else begin
                  exp_val = int'(exp_q.pop_front());
                  chk(int'(rx_byte) == exp_val, tag, "byte", int'(rx_byte), exp_val);
               end
               chk(rx_active, "R11", "active with valid", int'(rx_active), 1);
            end
            if (rx_eop) begin
               chk(exp_end == 1, "R8", "eop kind", 1, exp_end);
               chk(exp_q.size() == 0, "R8", "bytes left at eop", exp_q.size(), 0);
               chk(!rx_active, "R8", "active at eop", int'(rx_active), 0);
               got_end = 1;
            end
            if (rx_overflow) begin
               chk(exp_end == 2, "R9", "overflow kind", 2, exp_end);
               chk(exp_q.size() == 0, "R9", "bytes left at overflow", exp_q.size(), 0);
               got_end = 2;
            end
         end
      end
   end

   // 0 = J, 1 = K, 2 = SE0
   task automatic drive(input int lv, input int n);
      case (lv)
         0:       begin usb_dp = 1'b0; usb_dm = 1'b1; end
         1:       begin usb_dp = 1'b1; usb_dm = 1'b0; end
         default: begin usb_dp = 1'b0; usb_dm = 1'b0; end
      endcase
      repeat (n) @(negedge clk);
   endtask

   // behavioural encoder: sync, NRZI, stuffing, EOP
   task automatic send(input bit jit);
      int ones, cur, len, comp;
      lv_q = '{1, 0, 1, 0, 1, 0, 1, 1};
      exp_q.delete();
      ones = 1;
      cur  = 1;
      foreach (pk_q[i]) begin
         for (int b = 0; b < 8; b++) begin
            if (pk_q[i][b]) ones++;
            else begin cur = 1 - cur; ones = 0; end
            lv_q.push_back(cur);
            if (ones == 6) begin
               cur = 1 - cur;
               ones = 0;
               lv_q.push_back(cur);
            end
         end
      end
      foreach (pk_q[i]) if (i < MAXB) exp_q.push_back(pk_q[i]);
      exp_end    = (pk_q.size() > MAXB) ? 2 : 1;
      got_end    = 0;
      saw_active = 1'b0;
      comp       = 0;
      for (int k = 0; k < lv_q.size(); k++) begin
         len = OVS;
         if (jit && k >= 8) begin
            if (comp != 0) begin
               len  = comp;
               comp = 0;
            end else if (k % 5 == 2 && k + 1 < lv_q.size() &&
                         lv_q[k] != lv_q[k-1] && lv_q[k+1] != lv_q[k]) begin
               len  = HALF + 1;          // edge lands on the sample point (R10)
               comp = 2 * OVS - len;
            end else begin
               len = OVS - 1 + (k % 3);
            end
         end
         drive(lv_q[k], len);
      end
      drive(2, 2 * OVS);
      drive(0, OVS + 24);
      chk(got_end == exp_end, (exp_end == 2) ? "R9" : "R8", "packet end kind", got_end, exp_end);
      chk(exp_q.size() == 0, tag, "bytes not received", exp_q.size(), 0);
      chk(saw_active, "R2", "lock on sync", int'(saw_active), 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(rx_byte == 8'h00, "R1", "rx_byte in reset", int'(rx_byte), 0);
      chk(!rx_valid, "R1", "rx_valid in reset", int'(rx_valid), 0);
      chk(!rx_eop, "R1", "rx_eop in reset", int'(rx_eop), 0);
      chk(!rx_overflow, "R1", "rx_overflow in reset", int'(rx_overflow), 0);
      chk(!rx_active, "R1", "rx_active in reset", int'(rx_active), 0);
      rst_n = 1'b1;
      drive(0, 40);

      // R5 NRZI with mixed bytes
      tag = "R5";
      pk_q = '{8'h69, 8'h00, 8'h10, 8'hB4};
      send(1'b0);

      // R6 stuffing at many bit positions
      tag = "R6";
      pk_q = '{8'hFF, 8'hFF, 8'h7F, 8'hFE, 8'h3F, 8'hFC, 8'h1F, 8'hF8};
      send(1'b0);

      // R7 all-zero and walking bytes
      tag = "R7";
      pk_q = '{8'h00, 8'h00, 8'h01, 8'h80};
      send(1'b0);

      // R9 overflow, then a normal packet after the drain
      tag = "R9";
      pk_q.delete();
      for (int i = 0; i < MAXB + 2; i++) pk_q.push_back(8'(8'h11 * i + 3));
      send(1'b0);
      tag = "R9";
      pk_q = '{8'hC3, 8'h5A};
      send(1'b0);

      // R10 jittered bit lengths, edges coinciding with samples
      tag = "R10";
      pk_q = '{8'hFF, 8'hA5, 8'h0F, 8'hF0, 8'h3C, 8'h81, 8'h55, 8'hAA};
      send(1'b1);

      // R3 truncated sync: no activity, then a full packet locks
      quiet = 1'b1;
      quiet_hit = 1'b0;
      drive(1, OVS); drive(0, OVS); drive(1, OVS);
      drive(0, OVS); drive(1, OVS); drive(0, 6 * OVS);
      quiet = 1'b0;
      chk(!quiet_hit, "R3", "activity after truncated sync", int'(quiet_hit), 0);
      tag = "R3";
      pk_q = '{8'h2D, 8'hE1};
      send(1'b0);

      // R4 K after a long SE0 with no J in between must not lock
      quiet = 1'b1;
      quiet_hit = 1'b0;
      drive(0, 2 * OVS);
      drive(2, KWAIT + 3 * OVS);
      drive(1, 3 * OVS);
      drive(2, 2 * OVS);
      drive(0, 6 * OVS);
      quiet = 1'b0;
      chk(!quiet_hit, "R4", "lock without J after timeout", int'(quiet_hit), 0);
      tag = "R4";
      pk_q = '{8'h96};
      send(1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule